// File: doc/BRIEF.md
# Select-Gated Synchronous Serial Port with Mode-Fault Latch

This block wraps an 8-bit clock-synchronous shift engine with the logic that decides, from a single select pin, whether the port may drive the serial bus. A role input sets the port up either as the bus clock source (master) or as a clocked follower (slave). The select pin means something different in each role. For a follower, a low level picks the port, and a high level makes it release its data line and disregard the bus clock. For a clock source, a high level grants the right to transmit, and a low level reports that some other source holds the bus.

When a clock source sees the pin low, it releases both its data and clock lines and latches a mode-fault flag. The flag stays set until software clears it, and the clear is honoured only while the pin is high. A transfer that is in progress when the pin drops is abandoned, and the transmit-complete pulse still fires so that an interrupt routine can read the flag. A separate enable input turns all select handling off, and the port then runs as if the pin always allowed it. The select pin, the external bus clock and incoming data are each passed through a synchronizer. Frames go out LSB first, and the generated clock idles high.

Top module: `sel_serial_port`

## Requirements
- R1: While reset is held: sdata_out=1, sclk_out=1, sdata_oe=0, sclk_oe=0, mode_err=0, tx_done=0, rx_data=0.
- R2: In master role with transmission permitted, a tx_req starts a frame. The frame has 8 rising edges of sclk_out, each half period HALF_DIV system cycles long, with sdata_out carrying tx_data bit 0 first. sclk_out is 1 before and after the frame.
- R3: In master role, sdata_in is sampled on each rising edge of sclk_out, LSB first. At the end of the frame rx_data holds the received byte and tx_done is high for exactly one cycle.
- R4: With sel_en=0 the select pin has no effect. A master transfers with the pin low and never sets mode_err, and a slave shifts with the pin high and drives sdata_oe=1.
- R5: In master role with sel_en=1 and the pin low, mode_err becomes 1 and both sdata_oe and sclk_oe become 0 within 4 cycles.
- R6: mode_err is sticky. It stays 1 after the pin returns high, and while it is 1 a tx_req produces no sclk_out edges and no tx_done.
- R7: An err_clr pulse while the synchronized pin is low leaves mode_err at 1. The same pulse while the pin is high clears mode_err, and in master role sdata_oe and sclk_oe return to 1.
- R8: If the pin falls during a master frame, the frame is abandoned: tx_done pulses once, sclk_out returns to 1 and the bit count restarts. After clearing, the next frame transfers a whole byte correctly.
- R9: In slave role with the pin low (sel_en=1), sdata_oe=1 and the port shifts on the external clock. It changes sdata_out after falling edges and samples sdata_in on rising edges, LSB first, sending tx_data loaded earlier. After 8 rising edges rx_data holds the byte and tx_done pulses once. sclk_oe is 0 in slave role.
- R10: In slave role with sel_en=1 and the pin high, sdata_oe=0 and external clock edges are ignored: rx_data does not change and tx_done stays 0.
- R11: Deselecting a slave part-way through a frame discards the bits received so far. The next full frame is received correctly.
- R12: mode_err is never set in slave role, whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pin | input | 1 | Select pin (asynchronous) |
| sel_en | input | 1 | 1 enables select-pin handling |
| role_slave | input | 1 | 1 = slave role, 0 = master role |
| sclk_in | input | 1 | External serial clock (slave role) |
| sdata_in | input | 1 | Serial data in |
| tx_req | input | 1 | One-cycle request to load tx_data |
| tx_data | input | DATA_W | Byte to transmit |
| err_clr | input | 1 | Software request to clear mode_err |
| sdata_out | output | 1 | Serial data out |
| sdata_oe | output | 1 | Output enable for sdata_out |
| sclk_out | output | 1 | Generated serial clock (master role) |
| sclk_oe | output | 1 | Output enable for sclk_out |
| mode_err | output | 1 | Sticky mode-fault flag |
| tx_done | output | 1 | One-cycle transmit-complete pulse |
| rx_data | output | DATA_W | Last received byte |

## Verification
The bench runs every byte value through the master in loopback. A wrong bit order or an off-by-one bit count would corrupt the captured serial stream or the received byte. It drops the pin mid-frame, and then demands one tx_done and an intact next byte: a design that failed to reset its counter would misalign the following frame, and a design that forgot the abort pulse would leave an interrupt routine waiting. It attempts a clear while the pin is low and a transmit while the fault is latched. A design that cleared too eagerly, or that re-drove the bus, would show enabled outputs or clock edges. On the slave side it clocks a deselected port and a port interrupted mid-frame, which catches logic that listens while released or keeps stale bits.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_e;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int                WIDTH  = 1,
  parameter int                STAGES = 2,
  parameter logic [WIDTH-1:0]  INIT   = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_clkdiv.sv
module sp_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      sclk_o <= 1'b1;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (cnt == LAST) begin
        cnt    <= '0;
        sclk_o <= !sclk_o;
        rise_o <= !sclk_o;
        fall_o <= sclk_o;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_shift.sv
module sp_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         restart,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rise,
  input  logic         fall,
  input  logic         sdi,
  output logic         line,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_data
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh;
  logic [W-2:0]  acc;
  logic [CW-1:0] cnt;
  logic          loaded;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '1;
      acc     <= '0;
      cnt     <= '0;
      loaded  <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (flush) begin
        sh     <= '1;
        cnt    <= '0;
        loaded <= 1'b0;
      end else if (restart && cnt != '0) begin
        cnt <= '0;
      end else if (rise) begin
        acc <= {sdi, acc[W-2:1]};
        if (cnt == LAST) begin
          cnt     <= '0;
          done    <= 1'b1;
          rx_data <= {sdi, acc};
          loaded  <= 1'b0;
          sh      <= '1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (fall && cnt != '0) begin
        sh <= {1'b1, sh[W-1:1]};
      end else if (load && !loaded && cnt == '0) begin
        sh     <= load_data;
        loaded <= 1'b1;
      end
    end
  end

  assign line = sh[0];
  assign busy = loaded || (cnt != '0);
endmodule

// File: rtl/sel_serial_port.sv
module sel_serial_port
  import sp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_pin,
  input  logic              sel_en,
  input  logic              role_slave,
  input  logic              sclk_in,
  input  logic              sdata_in,
  input  logic              tx_req,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              err_clr,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              mode_err,
  output logic              tx_done,
  output logic [DATA_W-1:0] rx_data
);
  role_e role;
  logic  is_slave;
  logic  sel_s, sclk_s, sdi_s, sclk_d;
  logic  ext_rise, ext_fall, div_rise, div_fall;
  logic  slave_sel, master_ok, err_set, err_next;
  logic  busy, sh_done, abort, clk_run, restart, load;
  logic  rise, fall;

  assign role     = role_e'(role_slave);
  assign is_slave = (role == ROLE_SLAVE);

  sp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sel_pin, sclk_in, sdata_in}),
    .q   ({sel_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b1;
    else     sclk_d <= sclk_s;
  end

  assign ext_rise  = !sclk_d && sclk_s;
  assign ext_fall  = sclk_d && !sclk_s;

  assign slave_sel = !sel_en || !sel_s;
  assign master_ok = !sel_en || sel_s;
  assign err_set   = !is_slave && sel_en && !sel_s;
  assign err_next  = err_set ? 1'b1 : ((err_clr && sel_s) ? 1'b0 : mode_err);

  assign abort   = !is_slave && busy && !master_ok;
  assign clk_run = !is_slave && busy && master_ok && !mode_err;
  assign restart = is_slave && !slave_sel;
  assign load    = tx_req && (is_slave || (master_ok && !mode_err));
  assign rise    = is_slave ? (ext_rise && slave_sel) : div_rise;
  assign fall    = is_slave ? (ext_fall && slave_sel) : div_fall;

  sp_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (clk_run),
    .sclk_o (sclk_out),
    .rise_o (div_rise),
    .fall_o (div_fall)
  );

  sp_shift #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .flush     (abort),
    .restart   (restart),
    .load      (load),
    .load_data (tx_data),
    .rise      (rise),
    .fall      (fall),
    .sdi       (sdi_s),
    .line      (sdata_out),
    .busy      (busy),
    .done      (sh_done),
    .rx_data   (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_err <= 1'b0;
      sdata_oe <= 1'b0;
      sclk_oe  <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      mode_err <= err_next;
      sdata_oe <= is_slave ? slave_sel : !err_next;
      sclk_oe  <= !is_slave && !err_next;
      tx_done  <= sh_done || abort;
    end
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              role_slave,
  input logic              sel_en,
  input logic              sel_s,
  input logic              err_clr,
  input logic              mode_err,
  input logic              sdata_oe,
  input logic              sclk_oe,
  input logic              sclk_out,
  input logic              clk_run,
  input logic              tx_done,
  input logic [DATA_W-1:0] rx_data
);
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!clk_run) |-> sclk_out);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  assert_fault_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (!role_slave && sel_en && !sel_s) |=> mode_err);

  assert_fault_releases_R5: assert property (@(posedge clk) disable iff (rst)
    (!role_slave && $past(!role_slave) && mode_err) |-> (!sdata_oe && !sclk_oe));

  assert_clear_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_err && !sel_s) |=> mode_err);

  assert_clear_honoured_R7: assert property (@(posedge clk) disable iff (rst)
    (err_clr && sel_s) |=> !mode_err);

  assert_slave_clk_off_R9: assert property (@(posedge clk) disable iff (rst)
    $past(role_slave) |-> !sclk_oe);

  assert_deselect_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $past(role_slave && sel_en && sel_s) |-> $stable(rx_data));

  assert_slave_no_fault_R12: assert property (@(posedge clk) disable iff (rst)
    $past(role_slave && !mode_err) |-> !mode_err);
endmodule

bind sel_serial_port sp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .role_slave (role_slave),
  .sel_en     (sel_en),
  .sel_s      (sel_s),
  .err_clr    (err_clr),
  .mode_err   (mode_err),
  .sdata_oe   (sdata_oe),
  .sclk_oe    (sclk_oe),
  .sclk_out   (sclk_out),
  .clk_run    (clk_run),
  .tx_done    (tx_done),
  .rx_data    (rx_data)
);

// File: tb/sel_serial_port_test.sv
`timescale 1ns/1ps
module sel_serial_port_test;
  localparam int DATA_W     = 8;
  localparam int HALF_DIV   = 4;
  localparam int FRAME_WAIT = 2 * DATA_W * HALF_DIV + HALF_DIV + 20;
  localparam int SH         = 6;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_pin = 1'b1, sel_en = 1'b1, role_slave = 1'b0;
  logic sclk_drv = 1'b1, sd_drv = 1'b1, lb = 1'b1;
  logic tx_req = 1'b0, err_clr = 1'b0;
  logic [DATA_W-1:0] tx_data = '0;
  logic sdata_in;
  logic sdata_out, sdata_oe, sclk_out, sclk_oe, mode_err, tx_done;
  logic [DATA_W-1:0] rx_data;

  int total = 0;
  int fails = 0;
  int done_cnt = 0;
  int rise_cnt = 0;
  logic sclk_prev = 1'b1;
  logic [DATA_W-1:0] cap = '0;
  logic [DATA_W-1:0] scap = '0;

  always #4 clk = ~clk;

  assign sdata_in = lb ? sdata_out : sd_drv;

  sel_serial_port #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) uut (
    .clk(clk), .rst(rst), .sel_pin(sel_pin), .sel_en(sel_en),
    .role_slave(role_slave), .sclk_in(sclk_drv), .sdata_in(sdata_in),
    .tx_req(tx_req), .tx_data(tx_data), .err_clr(err_clr),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .mode_err(mode_err), .tx_done(tx_done),
    .rx_data(rx_data)
  );

  always @(negedge clk) begin
    if (tx_done) done_cnt <= done_cnt + 1;
    if (sclk_out && !sclk_prev) begin
      rise_cnt <= rise_cnt + 1;
      cap <= {sdata_out, cap[DATA_W-1:1]};
    end
    sclk_prev <= sclk_out;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic send(input logic [DATA_W-1:0] b);
    tx_data = b;
    tx_req  = 1'b1;
    tick(1);
    tx_req  = 1'b0;
  endtask

  task automatic master_frame(input logic [DATA_W-1:0] b, input string req);
    int rc0, dc0;
    rc0 = rise_cnt;
    dc0 = done_cnt;
    send(b);
    tick(FRAME_WAIT);
    chk(cap == b, req, "serial bits", int'(cap), int'(b));
    chk(rx_data == b, req, "loopback rx", int'(rx_data), int'(b));
    chk(done_cnt - dc0 == 1, req, "done pulses", done_cnt - dc0, 1);
    chk(rise_cnt - rc0 == DATA_W, req, "clock edges", rise_cnt - rc0, DATA_W);
    chk(sclk_out == 1'b1, req, "clock idle", int'(sclk_out), 1);
  endtask

  task automatic slave_bits(input logic [DATA_W-1:0] din, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sclk_drv = 1'b0;
      sd_drv   = din[i];
      tick(SH);
      scap = {sdata_out, scap[DATA_W-1:1]};
      sclk_drv = 1'b1;
      tick(SH);
    end
    tick(8);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", WD_CYCLES, WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    int rc0, dc0;
    logic [DATA_W-1:0] rx_hold;
    tick(3);
    // R1 reset state
    chk(sdata_out == 1'b1, "R1", "sdata_out", int'(sdata_out), 1);
    chk(sclk_out == 1'b1, "R1", "sclk_out", int'(sclk_out), 1);
    chk(sdata_oe == 1'b0, "R1", "sdata_oe", int'(sdata_oe), 0);
    chk(sclk_oe == 1'b0, "R1", "sclk_oe", int'(sclk_oe), 0);
    chk(mode_err == 1'b0, "R1", "mode_err", int'(mode_err), 0);
    chk(tx_done == 1'b0, "R1", "tx_done", int'(tx_done), 0);
    chk(rx_data == '0, "R1", "rx_data", int'(rx_data), 0);
    rst = 1'b0;
    tick(5);

    // R2 / R3: every byte through the master in loopback
    for (int v = 0; v < 256; v++) master_frame(DATA_W'(v), "R2_R3");

    // R4: select disabled, pin low, master still transfers
    sel_en  = 1'b0;
    sel_pin = 1'b0;
    tick(5);
    master_frame(8'h5A, "R4");
    chk(mode_err == 1'b0, "R4", "no fault", int'(mode_err), 0);
    chk(sclk_oe == 1'b1, "R4", "clock driven", int'(sclk_oe), 1);

    // R5: enable handling with pin low
    sel_en = 1'b1;
    tick(4);
    chk(mode_err == 1'b1, "R5", "fault set", int'(mode_err), 1);
    chk(sdata_oe == 1'b0, "R5", "data released", int'(sdata_oe), 0);
    chk(sclk_oe == 1'b0, "R5", "clock released", int'(sclk_oe), 0);

    // R6: sticky, transmit blocked
    sel_pin = 1'b1;
    tick(6);
    chk(mode_err == 1'b1, "R6", "sticky", int'(mode_err), 1);
    chk(sclk_oe == 1'b0, "R6", "still released", int'(sclk_oe), 0);
    rc0 = rise_cnt;
    dc0 = done_cnt;
    send(8'hF0);
    tick(FRAME_WAIT);
    chk(rise_cnt == rc0, "R6", "no clock", rise_cnt - rc0, 0);
    chk(done_cnt == dc0, "R6", "no done", done_cnt - dc0, 0);

    // R7: clear while low ignored, while high honoured
    sel_pin = 1'b0;
    tick(4);
    err_clr = 1'b1;
    tick(1);
    err_clr = 1'b0;
    tick(3);
    chk(mode_err == 1'b1, "R7", "clear ignored low", int'(mode_err), 1);
    sel_pin = 1'b1;
    tick(4);
    err_clr = 1'b1;
    tick(1);
    err_clr = 1'b0;
    tick(2);
    chk(mode_err == 1'b0, "R7", "clear high", int'(mode_err), 0);
    chk(sdata_oe == 1'b1, "R7", "data driven", int'(sdata_oe), 1);
    chk(sclk_oe == 1'b1, "R7", "clock driven", int'(sclk_oe), 1);

    // R8: pin falls mid-frame
    rc0 = rise_cnt;
    dc0 = done_cnt;
    send(8'hC3);
    while (rise_cnt - rc0 < 3) tick(1);
    sel_pin = 1'b0;
    tick(10);
    chk(done_cnt - dc0 == 1, "R8", "abort done pulse", done_cnt - dc0, 1);
    chk(sclk_out == 1'b1, "R8", "clock high", int'(sclk_out), 1);
    chk(rise_cnt - rc0 == 3, "R8", "edges stop", rise_cnt - rc0, 3);
    chk(mode_err == 1'b1, "R8", "fault", int'(mode_err), 1);
    sel_pin = 1'b1;
    tick(4);
    err_clr = 1'b1;
    tick(1);
    err_clr = 1'b0;
    tick(3);
    master_frame(8'h96, "R8");

    // R10: slave deselected ignores clock
    role_slave = 1'b1;
    lb = 1'b0;
    tick(5);
    chk(sdata_oe == 1'b0, "R10", "data released", int'(sdata_oe), 0);
    chk(sclk_oe == 1'b0, "R9", "slave clock off", int'(sclk_oe), 0);
    rx_hold = rx_data;
    dc0 = done_cnt;
    slave_bits(8'h0F, DATA_W);
    chk(rx_data == rx_hold, "R10", "rx unchanged", int'(rx_data), int'(rx_hold));
    chk(done_cnt == dc0, "R10", "no done", done_cnt - dc0, 0);

    // R9: selected slave frames
    for (int k = 0; k < 16; k++) begin
      logic [DATA_W-1:0] outb, inb;
      outb = DATA_W'(k * 53 + 7);
      inb  = DATA_W'(k * 37 + 11);
      sel_pin = 1'b1;
      tick(5);
      send(outb);
      sel_pin = 1'b0;
      tick(5);
      chk(sdata_oe == 1'b1, "R9", "data driven", int'(sdata_oe), 1);
      dc0 = done_cnt;
      slave_bits(inb, DATA_W);
      chk(scap == outb, "R9", "slave tx bits", int'(scap), int'(outb));
      chk(rx_data == inb, "R9", "slave rx", int'(rx_data), int'(inb));
      chk(done_cnt - dc0 == 1, "R9", "done pulse", done_cnt - dc0, 1);
      chk(mode_err == 1'b0, "R12", "no fault in slave", int'(mode_err), 0);
    end

    // R11: deselect mid-frame
    slave_bits(8'hFF, 3);
    sel_pin = 1'b1;
    tick(6);
    sel_pin = 1'b0;
    tick(6);
    dc0 = done_cnt;
    slave_bits(8'h5E, DATA_W);
    chk(rx_data == 8'h5E, "R11", "rx after restart", int'(rx_data), 'h5E);
    chk(done_cnt - dc0 == 1, "R11", "done pulse", done_cnt - dc0, 1);

    // R4 slave side: handling off, pin high, still shifts
    sel_en  = 1'b0;
    sel_pin = 1'b1;
    tick(5);
    chk(sdata_oe == 1'b1, "R4", "slave drives", int'(sdata_oe), 1);
    dc0 = done_cnt;
    slave_bits(8'h81, DATA_W);
    chk(rx_data == 8'h81, "R4", "slave rx", int'(rx_data), 'h81);
    chk(done_cnt - dc0 == 1, "R4", "done pulse", done_cnt - dc0, 1);

    // R12: pin toggling in slave role never faults
    sel_en = 1'b1;
    for (int t = 0; t < 4; t++) begin
      sel_pin = ~sel_pin;
      tick(5);
    end
    sel_pin = 1'b0;
    tick(6);
    chk(mode_err == 1'b0, "R12", "no fault", int'(mode_err), 0);

    summary();
    $finish;
  end
endmodule